// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block watches the load/store side of a processor core and flags data accesses that a debugger has asked to trap. It holds four comparator slots. Each slot stores a compare address, a compare data value, a mask count and a function field. The function field chooses the access direction and what is compared: the address alone, the data value alone, or both. A mask count N drops the low N address bits from the compare, so one slot can cover an aligned range of addresses. Instruction fetches never reach this block. Only the monitored load/store stream does.

A debugger programs the slots and a slot enable register over a simple word-addressed register port. When an enabled slot matches a valid access, the unit raises a one-cycle event toward the debug halt logic. It also sets a sticky per-slot matched flag. The debugger clears a flag by reading that slot's function register.

Register map (byte addresses, word aligned; any other address reads as zero and ignores writes):

| Address | Content |
|---|---|
| 0x00 | slot enable, bit i enables slot i |
| 0x10·(i+1) + 0x0 | slot i compare address |
| 0x10·(i+1) + 0x4 | slot i compare data |
| 0x10·(i+1) + 0x8 | slot i mask count, bits 3:0 |
| 0x10·(i+1) + 0xC | slot i function: bits 1:0 direction, bits 3:2 compare mode, bit 4 matched flag (read only) |

Top module: `watch_unit`

## Requirements
- R1: After reset, all slot registers and the enable register read as zero, `watch_evt_o` is low and `slot_hit_o` is zero.
- R2: A register write takes effect at the clock edge where `reg_req_i` and `reg_we_i` are high. A read loads `reg_rdata_o` at the edge of the request. The enable register keeps bits 3:0 and the mask register keeps bits 3:0. The function register keeps bits 3:0 and returns the matched flag in bit 4. Unmapped addresses read zero.
- R3: A slot can match only while its bit in the enable register is 1 and its direction field is not 00.
- R4: Direction field: 01 matches loads (`mon_write_i`=0), 10 matches stores (`mon_write_i`=1), 11 matches both.
- R5: Compare mode 00 (address): the access matches when its address equals the compare address with address bits N-1:0 ignored, where N (0 to 15) is the mask count.
- R6: Compare mode 01 (data): the access matches when `mon_data_i` equals the compare data on all 32 bits, whatever the address.
- R7: Compare mode 10 (both): the masked address compare and the exact data compare must both be true in the same access. Compare mode 11 never matches.
- R8: `watch_evt_o` is high for exactly the cycle after an access with `mon_valid_i`=1 that matches at least one slot. It is low otherwise. An access with `mon_valid_i`=0 has no effect.
- R9: A slot's bit in `slot_hit_o` sets in the cycle after that slot matches. It stays set through later non-matching accesses.
- R10: Reading a slot's function register returns the flag value from before the read and clears that slot's flag at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_req_i | input | 1 | register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | register byte address |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data, valid the cycle after a read |
| mon_valid_i | input | 1 | monitored data access valid |
| mon_write_i | input | 1 | monitored access is a store |
| mon_addr_i | input | 32 | monitored access address |
| mon_data_i | input | 32 | monitored load or store data |
| watch_evt_o | output | 1 | watchpoint event pulse |
| slot_hit_o | output | 4 | sticky per-slot matched flags |

## Verification
Each result falls due at a fixed cycle. Every register takes one edge. The event pulse and a matched flag show up one edge after the access that caused them. Read data appears, and the read-to-clear takes effect, one edge after the read request. The bench drives every input on the falling edge. It samples 1 ns after the next rising edge, so each check lands in the cycle after its stimulus. On every clock, a behavioural model updated at that same edge predicts the event line and all four flags, and the bench compares them against the outputs.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MASK_W = 4;

  typedef enum logic [1:0] {
    MODE_ADDR = 2'b00,
    MODE_DATA = 2'b01,
    MODE_BOTH = 2'b10,
    MODE_NONE = 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [MASK_W-1:0] mask;
    cmp_mode_e         mode;
    logic [1:0]        dir;  // bit0 loads, bit1 stores
  } slot_cfg_t;
endpackage

// File: rtl/watch_regs.sv
module watch_regs
  import watch_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned RAW       = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [RAW-1:0]             addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_SLOTS-1:0]       flag_i,
  output slot_cfg_t [NUM_SLOTS-1:0]  cfg_o,
  output logic [NUM_SLOTS-1:0]       en_o,
  output logic [NUM_SLOTS-1:0]       clr_o
);
  localparam int unsigned IDX_W = RAW - 4;

  logic                 ctl_sel;
  logic [NUM_SLOTS-1:0] slot_sel;
  logic [1:0]           sub;
  logic                 wr, rd;
  logic [DATA_W-1:0]    rd_mux;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign sub     = addr_i[3:2];
  assign ctl_sel = (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             en_o <= '0;
    else if (wr && ctl_sel)  en_o <= wdata_i[NUM_SLOTS-1:0];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_cfg_t cfg_q;
    assign slot_sel[i] = (addr_i[1:0] == 2'b00) && (addr_i[RAW-1:4] == IDX_W'(i + 1));
    assign clr_o[i]    = rd && slot_sel[i] && (sub == 2'd3);
    assign cfg_o[i]    = cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (wr && slot_sel[i]) begin
        case (sub)
          2'd0: cfg_q.addr <= wdata_i[ADDR_W-1:0];
          2'd1: cfg_q.data <= wdata_i;
          2'd2: cfg_q.mask <= wdata_i[MASK_W-1:0];
          default: begin
            cfg_q.dir  <= wdata_i[1:0];
            cfg_q.mode <= cmp_mode_e'(wdata_i[3:2]);
          end
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctl_sel) rd_mux = DATA_W'(en_o);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_sel[i]) begin
        case (sub)
          2'd0:    rd_mux = DATA_W'(cfg_o[i].addr);
          2'd1:    rd_mux = cfg_o[i].data;
          2'd2:    rd_mux = DATA_W'(cfg_o[i].mask);
          default: rd_mux = DATA_W'({flag_i[i], cfg_o[i].mode, cfg_o[i].dir});
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  // R2: enable register only changes on a control write
  a_r2_en_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && ctl_sel) |=> $stable(en_o));
endmodule

// File: rtl/watch_slot.sv
module watch_slot
  import watch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_cfg_t         cfg_i,
  input  logic              en_i,
  input  logic              mon_valid_i,
  input  logic              mon_write_i,
  input  logic [ADDR_W-1:0] mon_addr_i,
  input  logic [DATA_W-1:0] mon_data_i,
  input  logic              clr_i,
  output logic              hit_o,
  output logic              flag_o
);
  logic [ADDR_W-1:0] care;
  logic              a_ok, d_ok, dir_ok, sel_ok;

  assign care   = {ADDR_W{1'b1}} << cfg_i.mask;
  assign a_ok   = ((mon_addr_i ^ cfg_i.addr) & care) == '0;
  assign d_ok   = (mon_data_i == cfg_i.data);
  assign dir_ok = mon_write_i ? cfg_i.dir[1] : cfg_i.dir[0];

  always_comb begin
    case (cfg_i.mode)
      MODE_ADDR: sel_ok = a_ok;
      MODE_DATA: sel_ok = d_ok;
      MODE_BOTH: sel_ok = a_ok & d_ok;
      default:   sel_ok = 1'b0;
    endcase
  end

  assign hit_o = mon_valid_i & en_i & dir_ok & sel_ok;

  // set wins over read-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit_o)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R9: sticky until read
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  // R3: a disabled slot never sets its flag
  a_r3_off_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o && (!en_i || cfg_i.dir == 2'b00) |=> !flag_o);
  // R10: read clears unless a new hit arrives
  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !mon_valid_i |=> !flag_o);
endmodule

// File: rtl/watch_unit.sv
module watch_unit
  import watch_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned RAW       = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [RAW-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 mon_valid_i,
  input  logic                 mon_write_i,
  input  logic [ADDR_W-1:0]    mon_addr_i,
  input  logic [DATA_W-1:0]    mon_data_i,
  output logic                 watch_evt_o,
  output logic [NUM_SLOTS-1:0] slot_hit_o
);
  slot_cfg_t [NUM_SLOTS-1:0] cfg;
  logic [NUM_SLOTS-1:0]      en, clr, hit, flag;

  watch_regs #(.NUM_SLOTS(NUM_SLOTS), .RAW(RAW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .flag_i  (flag),
    .cfg_o   (cfg),
    .en_o    (en),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    watch_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_i       (cfg[i]),
      .en_i        (en[i]),
      .mon_valid_i (mon_valid_i),
      .mon_write_i (mon_write_i),
      .mon_addr_i  (mon_addr_i),
      .mon_data_i  (mon_data_i),
      .clr_i       (clr[i]),
      .hit_o       (hit[i]),
      .flag_o      (flag[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) watch_evt_o <= 1'b0;
    else         watch_evt_o <= |hit;
  end

  assign slot_hit_o = flag;

  // R8: no event without a valid access the cycle before
  a_r8_evt_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_valid_i |=> !watch_evt_o);
  // R9: every event leaves a flag behind
  a_r9_evt_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    watch_evt_o |-> slot_hit_o != '0);
endmodule

// File: tb/watch_unit_test.sv
`timescale 1ns/1ps
module watch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mon_valid = 1'b0, mon_write = 1'b0;
  logic [31:0] mon_addr = '0, mon_data = '0;
  logic        evt;
  logic [3:0]  flags;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model
  logic [3:0]  m_en;
  logic [31:0] m_a [4];
  logic [31:0] m_d [4];
  logic [3:0]  m_msk [4];
  logic [3:0]  m_fn [4];
  logic [3:0]  m_flg;
  logic        m_evt;

  always #2.5 clk = ~clk;

  watch_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mon_valid_i(mon_valid), .mon_write_i(mon_write),
    .mon_addr_i(mon_addr), .mon_data_i(mon_data),
    .watch_evt_o(evt), .slot_hit_o(flags)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " evt"}, 32'(evt), 32'(m_evt));
    chk({tag, " flags"}, 32'(flags), 32'(m_flg));
  endtask

  function automatic logic m_hit(int i, logic w, logic [31:0] a, logic [31:0] d);
    logic dir_ok, aok, dok, sel;
    dir_ok = w ? m_fn[i][1] : m_fn[i][0];
    aok = (a >> m_msk[i]) == (m_a[i] >> m_msk[i]);
    dok = (d == m_d[i]);
    case (m_fn[i][3:2])
      2'b00: sel = aok;
      2'b01: sel = dok;
      2'b10: sel = aok && dok;
      default: sel = 1'b0;
    endcase
    return m_en[i] && dir_ok && sel;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] ad);
    int s;
    if (ad == 8'h00) return 32'(m_en);
    s = int'(ad[7:4]) - 1;
    if (ad[1:0] != 0 || s < 0 || s > 3) return 32'h0;
    case (ad[3:2])
      2'd0: return m_a[s];
      2'd1: return m_d[s];
      2'd2: return 32'(m_msk[s]);
      default: return 32'({m_flg[s], m_fn[s]});
    endcase
  endfunction

  task automatic idle_drive();
    reg_req = 0; reg_we = 0; mon_valid = 0;
  endtask

  task automatic wr(logic [7:0] ad, logic [31:0] v);
    int s;
    @(negedge clk);
    idle_drive();
    reg_req = 1; reg_we = 1; reg_addr = ad; reg_wdata = v;
    @(posedge clk); #1;
    s = int'(ad[7:4]) - 1;
    if (ad == 8'h00) m_en = v[3:0];
    else if (ad[1:0] == 0 && s >= 0 && s <= 3)
      case (ad[3:2])
        2'd0: m_a[s] = v;
        2'd1: m_d[s] = v;
        2'd2: m_msk[s] = v[3:0];
        default: m_fn[s] = v[3:0];
      endcase
    m_evt = 0;
    chk_outs("R8 write cycle");
  endtask

  task automatic rd(logic [7:0] ad, string tag);
    logic [31:0] exp;
    int s;
    @(negedge clk);
    idle_drive();
    reg_req = 1; reg_we = 0; reg_addr = ad;
    exp = m_read(ad);
    @(posedge clk); #1;
    s = int'(ad[7:4]) - 1;
    if (ad[1:0] == 0 && ad[3:2] == 2'd3 && s >= 0 && s <= 3) m_flg[s] = 1'b0;
    m_evt = 0;
    chk({tag, " rdata"}, reg_rdata, exp);
    chk_outs({tag, " R10 after read"});
  endtask

  task automatic acc(logic v, logic w, logic [31:0] a, logic [31:0] d, string tag);
    logic [3:0] h;
    @(negedge clk);
    idle_drive();
    mon_valid = v; mon_write = w; mon_addr = a; mon_data = d;
    for (int i = 0; i < 4; i++) h[i] = v && m_hit(i, w, a, d);
    @(posedge clk); #1;
    m_evt = |h;
    m_flg = m_flg | h;
    chk_outs(tag);
  endtask

  task automatic clr_all();
    for (int i = 0; i < 4; i++) rd(8'((i + 1) * 16 + 12), "R10 clear");
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_flg = 0; m_evt = 0;
    for (int i = 0; i < 4; i++) begin m_a[i] = 0; m_d[i] = 0; m_msk[i] = 0; m_fn[i] = 0; end
    #12;
    chk_outs("R1 in reset");
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      rd(8'((i + 1) * 16), "R1 addr");
      rd(8'((i + 1) * 16 + 12), "R1 func");
    end
    rd(8'h00, "R1 enable");

    // R2 register readback and widths
    wr(8'h10, 32'hDEAD_BEEF); rd(8'h10, "R2 addr");
    wr(8'h24, 32'h1234_5678); rd(8'h24, "R2 data");
    wr(8'h38, 32'hFFFF_FFF7); rd(8'h38, "R2 mask");
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, "R2 func");
    wr(8'h00, 32'hFFFF_FFF0); rd(8'h00, "R2 enable");
    wr(8'h90, 32'hAAAA_AAAA); rd(8'h90, "R2 unmapped");
    rd(8'h12, "R2 misaligned");
    wr(8'h4C, 0); wr(8'h38, 0);

    // R5 address mode, exact, store only
    wr(8'h10, 32'h2000_0100); wr(8'h18, 0); wr(8'h1C, 32'h2);
    acc(1, 1, 32'h2000_0100, 0, "R3 enable off");
    wr(8'h00, 32'h1);
    acc(1, 1, 32'h2000_0100, 0, "R5 exact hit");
    acc(1, 1, 32'h2000_0104, 0, "R9 sticky no hit");
    acc(1, 0, 32'h2000_0100, 0, "R4 load vs store-only");
    acc(0, 1, 32'h2000_0100, 0, "R8 invalid access");
    rd(8'h1C, "R10 func read flag");
    acc(1, 1, 32'h2000_0101, 0, "R5 mask0 miss");
    // R5 mask range
    wr(8'h18, 32'h4);
    acc(1, 1, 32'h2000_010F, 0, "R5 mask4 top");
    acc(1, 1, 32'h2000_0110, 0, "R5 mask4 outside");
    wr(8'h18, 32'hF);
    acc(1, 1, 32'h2000_7FFF, 0, "R5 mask15 inside");
    acc(1, 1, 32'h2000_8000, 0, "R5 mask15 outside");
    clr_all();

    // R4 directions
    wr(8'h1C, 32'h1);
    acc(1, 0, 32'h2000_0000, 0, "R4 load-only load");
    acc(1, 1, 32'h2000_0000, 0, "R4 load-only store");
    wr(8'h1C, 32'h3);
    acc(1, 1, 32'h2000_1000, 0, "R4 either store");
    clr_all();
    wr(8'h1C, 32'h0);
    acc(1, 1, 32'h2000_0000, 0, "R3 dir00");

    // R6 data mode on slot1
    wr(8'h24, 32'hCAFE_F00D); wr(8'h2C, 32'h7); wr(8'h00, 32'h3);
    acc(1, 0, 32'h1234_0000, 32'hCAFE_F00D, "R6 data hit any addr");
    acc(1, 0, 32'h1234_0000, 32'hCAFE_F00C, "R6 data lsb miss");
    acc(1, 1, 32'h0, 32'h4AFE_F00D, "R6 data msb miss");
    clr_all();

    // R7 both mode on slot2, and mode 11 on slot3
    wr(8'h30, 32'h4000_0040); wr(8'h34, 32'h5555_AAAA); wr(8'h38, 32'h2);
    wr(8'h3C, 32'hB); wr(8'h00, 32'h4);
    acc(1, 1, 32'h4000_0041, 32'h5555_AAAB, "R7 addr only");
    acc(1, 1, 32'h4000_0080, 32'h5555_AAAA, "R7 data only");
    acc(1, 1, 32'h4000_0043, 32'h5555_AAAA, "R7 both hit");
    wr(8'h40, 32'h0); wr(8'h44, 32'h0); wr(8'h4C, 32'hF); wr(8'h00, 32'h8);
    acc(1, 1, 32'h0, 32'h0, "R7 mode11 never");
    clr_all();

    // R8 several slots at once, back to back pulses
    wr(8'h00, 32'hF); wr(8'h4C, 32'h3); wr(8'h1C, 32'h3); wr(8'h18, 32'h0);
    wr(8'h10, 32'h0);
    acc(1, 0, 32'h0, 32'hCAFE_F00D, "R8 multi-slot");
    acc(1, 0, 32'h0, 32'h0, "R8 back to back");
    acc(0, 0, 32'h0, 32'h0, "R8 pulse ends");
    rd(8'h1C, "R10 slot0");
    rd(8'h1C, "R10 slot0 again");
    rd(8'h4C, "R10 slot3");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule